// File: doc/BRIEF.md
# Two-Level Translation Table Walker

This block resolves one 32-bit virtual address into a physical address by reading translation descriptors from memory. When a translation cache misses, the caller hands it the virtual address and the upper bits of the table base. The walker reads one first-level word from the table that the base points to. That word either maps a 1 MB section directly, points to a coarse second-level table, or marks the address as untranslatable. For a coarse entry the walker reads one more word, a small-page descriptor covering 4 KB. The result is the physical address, the domain number and the cacheable and bufferable attributes, or a fault code that says where the walk stopped.

Every descriptor address is built by OR-ing index bits from the virtual address into a naturally aligned base. The walker sends all its fetches as physical addresses and never translates its own reads. It runs one walk at a time.

The request side is a valid/ready stream. `req_ready` is high only while the walker is idle, so a request is taken only in the cycle where both are high. A request presented during a walk is not taken. The response side is also valid/ready. `rsp_valid` stays high and every response field stays frozen until `rsp_ready` is seen high at a clock edge. Back-pressure on the response therefore stalls the walker with no loss. The memory port is request/grant: `mem_req` and `mem_addr` stay steady until `mem_gnt`. The read word comes back with `mem_rvalid` in a later cycle.

Top module: `xlat_walker`

## Requirements
- R1: After reset `req_ready` is 1, and both `mem_req` and `rsp_valid` are 0.
- R2: A request is accepted only when `req_valid` and `req_ready` are both 1. From acceptance until the response is taken, `req_ready` is 0. Requests offered in that time change neither the fetch addresses nor the response.
- R3: The first fetch address is `{tbl_base, vaddr[31:20], 2'b00}`. This is a 16 KB aligned table of 4096 word entries.
- R4: `mem_req` and `mem_addr` hold until a cycle with `mem_gnt` high. The fetched word is taken on the first `mem_rvalid` after the grant. No fetch is issued while a response is pending.
- R5: First-level bits [1:0] = 2'b10 with bit 18 = 0 is a section. The walk ends after one fetch with `rsp_paddr = {d1[31:20], vaddr[19:0]}`, `rsp_cacheable = d1[3]`, `rsp_bufferable = d1[2]` and `rsp_fault = 0` (none).
- R6: First-level bits [1:0] = 2'b10 with bit 18 = 1 ends the walk after one fetch with `rsp_fault = 2` (large section).
- R7: First-level bits [1:0] = 2'b00 or 2'b11 ends the walk after one fetch with `rsp_fault = 1` (first level invalid).
- R8: First-level bits [1:0] = 2'b01 starts a second fetch at `{d1[31:10], vaddr[19:12], 2'b00}`.
- R9: Second-level bits [1:0] = 2'b10 gives `rsp_paddr = {d2[31:12], vaddr[11:0]}`, `rsp_cacheable = d2[3]`, `rsp_bufferable = d2[2]` and `rsp_fault = 0`.
- R10: Any other second-level code (2'b00, 2'b01, 2'b11) gives `rsp_fault = 3` (second level invalid).
- R11: `rsp_domain` equals first-level bits [8:5] in every response.
- R12: When `rsp_fault` is not 0, `rsp_paddr` is 0 and both attribute bits are 0.
- R13: The response holds while `rsp_ready` is 0. After the handshake edge the walker is idle again, with `rsp_valid` = 0 and `req_ready` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Walk request offered |
| req_ready | output | 1 | Walker idle, request can be taken |
| req_vaddr | input | 32 | Virtual address to resolve |
| tbl_base | input | 18 | Table base address bits 31:14 |
| mem_req | output | 1 | Descriptor read requested |
| mem_addr | output | 32 | Physical descriptor address, word aligned |
| mem_gnt | input | 1 | Read request accepted |
| mem_rvalid | input | 1 | Read word valid |
| mem_rdata | input | 32 | Descriptor word |
| rsp_valid | output | 1 | Result available |
| rsp_ready | input | 1 | Result taken |
| rsp_paddr | output | 32 | Physical address (0 on fault) |
| rsp_domain | output | 4 | Domain from first-level bits 8:5 |
| rsp_cacheable | output | 1 | Cacheable attribute |
| rsp_bufferable | output | 1 | Bufferable attribute |
| rsp_fault | output | 2 | 0 none, 1 first level invalid, 2 large section, 3 second level invalid |

## Verification
A wrong walk state shows up at the memory port within one cycle. Symptoms are a wrong or missing fetch address, a second fetch after a section, or a fetch while a response is pending. A wrong decode or a wrongly latched field reaches the ports on the first response after that fetch, as a wrong physical address, attribute, domain or fault code. A broken stall or busy path shows as a response field that moves while stalled, or as `req_ready` high in the cycle after an accept.

// File: rtl/xlat_walker_pkg.sv
package xlat_walker_pkg;

  // Bit positions that the descriptor format fixes
  localparam int CODE_W    = 2;
  localparam int BUF_BIT   = 2;
  localparam int CACHE_BIT = 3;
  localparam int DOM_LSB   = 5;
  localparam int LARGE_BIT = 18;

  typedef enum logic [1:0] {
    FLT_NONE       = 2'd0,
    FLT_L1_INVALID = 2'd1,
    FLT_L1_LARGE   = 2'd2,
    FLT_L2_INVALID = 2'd3
  } fault_e;

  typedef enum logic [1:0] {
    L1K_SECTION,
    L1K_COARSE,
    L1K_LARGE,
    L1K_INVALID
  } l1_kind_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_L1_REQ,
    ST_L1_WAIT,
    ST_L2_REQ,
    ST_L2_WAIT,
    ST_RESP
  } walk_state_e;

endpackage

// File: rtl/xlat_addr_gen.sv
module xlat_addr_gen #(
  parameter int ADDR_W   = 32,
  parameter int L1_IDX_W = 12,
  parameter int L2_IDX_W = 8,
  parameter int PAGE_W   = 12
) (
  input  logic                      second,
  input  logic [ADDR_W-1:L1_IDX_W+2] tbl_base,
  input  logic [ADDR_W-1:L2_IDX_W+2] coarse_base,
  input  logic [ADDR_W-1:PAGE_W]     va_hi,
  output logic [ADDR_W-1:0]          fetch_addr
);
  localparam int L1_ALIGN = L1_IDX_W + 2;
  localparam int L2_ALIGN = L2_IDX_W + 2;
  localparam int SECT_W   = L2_IDX_W + PAGE_W;

  logic [ADDR_W-1:0] l1_base, l1_off, l2_base, l2_off;

  // Aligned bases with index bits OR-ed into the cleared low part
  assign l1_base = {tbl_base, {L1_ALIGN{1'b0}}};
  assign l1_off  = ADDR_W'({va_hi[ADDR_W-1 -: L1_IDX_W], 2'b00});
  assign l2_base = {coarse_base, {L2_ALIGN{1'b0}}};
  assign l2_off  = ADDR_W'({va_hi[SECT_W-1 -: L2_IDX_W], 2'b00});

  assign fetch_addr = second ? (l2_base | l2_off) : (l1_base | l1_off);
endmodule

// File: rtl/xlat_l1_decode.sv
module xlat_l1_decode
  import xlat_walker_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int L2_IDX_W = 8,
  parameter int PAGE_W   = 12,
  parameter int DOM_W    = 4
) (
  input  logic [ADDR_W-1:0]          desc,
  output l1_kind_e                   kind,
  output logic [DOM_W-1:0]           domain,
  output logic [ADDR_W-1:L2_IDX_W+PAGE_W] sect_hi,
  output logic [ADDR_W-1:L2_IDX_W+2] coarse_hi,
  output logic                       cacheable,
  output logic                       bufferable
);
  localparam int SECT_W = L2_IDX_W + PAGE_W;

  logic unused_bits;
  assign unused_bits = ^desc;

  always_comb begin
    unique case (desc[CODE_W-1:0])
      2'b10:   kind = desc[LARGE_BIT] ? L1K_LARGE : L1K_SECTION;
      2'b01:   kind = L1K_COARSE;
      default: kind = L1K_INVALID;
    endcase
  end

  assign domain     = desc[DOM_LSB +: DOM_W];
  assign sect_hi    = desc[ADDR_W-1:SECT_W];
  assign coarse_hi  = desc[ADDR_W-1:L2_IDX_W+2];
  assign cacheable  = desc[CACHE_BIT];
  assign bufferable = desc[BUF_BIT];
endmodule

// File: rtl/xlat_l2_decode.sv
module xlat_l2_decode
  import xlat_walker_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int PAGE_W = 12
) (
  input  logic [ADDR_W-1:0]      desc,
  output logic                   page_ok,
  output logic [ADDR_W-1:PAGE_W] page_hi,
  output logic                   cacheable,
  output logic                   bufferable
);
  logic unused_bits;
  assign unused_bits = ^desc;

  assign page_ok    = (desc[CODE_W-1:0] == 2'b10);
  assign page_hi    = desc[ADDR_W-1:PAGE_W];
  assign cacheable  = desc[CACHE_BIT];
  assign bufferable = desc[BUF_BIT];
endmodule

// File: rtl/xlat_walker.sv
module xlat_walker
  import xlat_walker_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int L1_IDX_W = 12,
  parameter int L2_IDX_W = 8,
  parameter int PAGE_W   = 12,
  parameter int DOM_W    = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       req_valid,
  output logic                       req_ready,
  input  logic [ADDR_W-1:0]          req_vaddr,
  input  logic [ADDR_W-1:L1_IDX_W+2] tbl_base,
  output logic                       mem_req,
  output logic [ADDR_W-1:0]          mem_addr,
  input  logic                       mem_gnt,
  input  logic                       mem_rvalid,
  input  logic [ADDR_W-1:0]          mem_rdata,
  output logic                       rsp_valid,
  input  logic                       rsp_ready,
  output logic [ADDR_W-1:0]          rsp_paddr,
  output logic [DOM_W-1:0]           rsp_domain,
  output logic                       rsp_cacheable,
  output logic                       rsp_bufferable,
  output logic [1:0]                 rsp_fault
);
  localparam int SECT_W   = L2_IDX_W + PAGE_W;
  localparam int L1_ALIGN = L1_IDX_W + 2;
  localparam int L2_ALIGN = L2_IDX_W + 2;

  walk_state_e state;
  logic [ADDR_W-1:0]        va_q;
  logic [ADDR_W-1:L1_ALIGN] base_q;
  logic [ADDR_W-1:L2_ALIGN] coarse_q;
  fault_e                   fault_q;

  l1_kind_e                 l1_kind;
  logic [DOM_W-1:0]         l1_dom;
  logic [ADDR_W-1:SECT_W]   l1_sect_hi;
  logic [ADDR_W-1:L2_ALIGN] l1_coarse_hi;
  logic                     l1_c, l1_b;
  logic                     l2_ok;
  logic [ADDR_W-1:PAGE_W]   l2_page_hi;
  logic                     l2_c, l2_b;

  xlat_l1_decode #(.ADDR_W(ADDR_W), .L2_IDX_W(L2_IDX_W), .PAGE_W(PAGE_W), .DOM_W(DOM_W)) u_l1 (
    .desc(mem_rdata), .kind(l1_kind), .domain(l1_dom), .sect_hi(l1_sect_hi),
    .coarse_hi(l1_coarse_hi), .cacheable(l1_c), .bufferable(l1_b)
  );

  xlat_l2_decode #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_l2 (
    .desc(mem_rdata), .page_ok(l2_ok), .page_hi(l2_page_hi),
    .cacheable(l2_c), .bufferable(l2_b)
  );

  xlat_addr_gen #(.ADDR_W(ADDR_W), .L1_IDX_W(L1_IDX_W), .L2_IDX_W(L2_IDX_W), .PAGE_W(PAGE_W)) u_addr (
    .second(state == ST_L2_REQ), .tbl_base(base_q), .coarse_base(coarse_q),
    .va_hi(va_q[ADDR_W-1:PAGE_W]), .fetch_addr(mem_addr)
  );

  assign req_ready = (state == ST_IDLE);
  assign mem_req   = (state == ST_L1_REQ) || (state == ST_L2_REQ);
  assign rsp_valid = (state == ST_RESP);
  assign rsp_fault = fault_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state          <= ST_IDLE;
      va_q           <= '0;
      base_q         <= '0;
      coarse_q       <= '0;
      fault_q        <= FLT_NONE;
      rsp_paddr      <= '0;
      rsp_domain     <= '0;
      rsp_cacheable  <= 1'b0;
      rsp_bufferable <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: if (req_valid) begin
          va_q   <= req_vaddr;
          base_q <= tbl_base;
          state  <= ST_L1_REQ;
        end
        ST_L1_REQ: if (mem_gnt) state <= ST_L1_WAIT;
        ST_L1_WAIT: if (mem_rvalid) begin
          rsp_domain     <= l1_dom;
          coarse_q       <= l1_coarse_hi;
          rsp_paddr      <= '0;
          rsp_cacheable  <= 1'b0;
          rsp_bufferable <= 1'b0;
          state          <= ST_RESP;
          unique case (l1_kind)
            L1K_SECTION: begin
              rsp_paddr      <= {l1_sect_hi, va_q[SECT_W-1:0]};
              rsp_cacheable  <= l1_c;
              rsp_bufferable <= l1_b;
              fault_q        <= FLT_NONE;
            end
            L1K_COARSE:  state   <= ST_L2_REQ;
            L1K_LARGE:   fault_q <= FLT_L1_LARGE;
            default:     fault_q <= FLT_L1_INVALID;
          endcase
        end
        ST_L2_REQ: if (mem_gnt) state <= ST_L2_WAIT;
        ST_L2_WAIT: if (mem_rvalid) begin
          state <= ST_RESP;
          if (l2_ok) begin
            rsp_paddr      <= {l2_page_hi, va_q[PAGE_W-1:0]};
            rsp_cacheable  <= l2_c;
            rsp_bufferable <= l2_b;
            fault_q        <= FLT_NONE;
          end else begin
            fault_q        <= FLT_L2_INVALID;
          end
        end
        ST_RESP: if (rsp_ready) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R4: an unanswered fetch keeps its address
  assert_fetch_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_gnt |=> mem_req && $stable(mem_addr));

  // R4: no fetch while a result waits
  assert_no_fetch_in_resp_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !mem_req);

  // R13: a stalled response does not move
  assert_rsp_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_paddr) && $stable(rsp_fault)
      && $stable(rsp_domain) && $stable(rsp_cacheable) && $stable(rsp_bufferable));

  // R2: busy right after an accept
  assert_busy_after_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> !req_ready);

  // R12: faulted results carry no address or attributes
  assert_fault_clean_R12: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && (rsp_fault != FLT_NONE) |-> (rsp_paddr == '0) && !rsp_cacheable && !rsp_bufferable);

  // R13: the handshake returns the walker to idle
  assert_idle_after_rsp_R13: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_ready |=> req_ready && !rsp_valid);
endmodule

// File: tb/xlat_walker_test.sv
module xlat_walker_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_vaddr = '0;
  logic [31:14] tbl_base = '0;
  logic        mem_req;
  logic [31:0] mem_addr;
  logic        mem_gnt = 1'b0;
  logic        mem_rvalid = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b0;
  logic [31:0] rsp_paddr;
  logic [3:0]  rsp_domain;
  logic        rsp_cacheable, rsp_bufferable;
  logic [1:0]  rsp_fault;

  int n_checks = 0;
  int n_fail = 0;
  int cyc = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  xlat_walker uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_vaddr(req_vaddr), .tbl_base(tbl_base), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_gnt(mem_gnt), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_paddr(rsp_paddr),
    .rsp_domain(rsp_domain), .rsp_cacheable(rsp_cacheable),
    .rsp_bufferable(rsp_bufferable), .rsp_fault(rsp_fault)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !finished) begin
      n_fail++;
      n_checks++;
      $display("FAIL watchdog actual %0d expected below 150000", cyc);
      finish_run();
    end
  end

  // Expected values from the requirements
  function automatic logic [31:0] l1_addr(input logic [17:0] base, input logic [31:0] va);
    return {base, va[31:20], 2'b00};                       // R3
  endfunction
  function automatic logic [31:0] l2_addr(input logic [31:0] d1, input logic [31:0] va);
    return {d1[31:10], va[19:12], 2'b00};                   // R8
  endfunction

  // Serve one fetch: check the address, grant after a random wait, return data later
  task automatic serve(input string tag, input logic [31:0] exp_addr, input logic [31:0] data);
    while (!mem_req) @(negedge clk);
    check(tag, mem_addr, exp_addr);
    repeat ($urandom_range(0, 2)) @(negedge clk);
    mem_gnt = 1'b1;
    @(negedge clk);
    mem_gnt = 1'b0;
    repeat ($urandom_range(0, 2)) @(negedge clk);
    mem_rvalid = 1'b1;
    mem_rdata  = data;
    @(negedge clk);
    mem_rvalid = 1'b0;
    mem_rdata  = $urandom;
  endtask

  task automatic walk(input logic [31:0] va, input logic [17:0] base,
                      input logic [31:0] d1, input logic [31:0] d2, input bit poke);
    bit two;
    logic [31:0] e_pa;
    logic e_c, e_b;
    logic [1:0] e_f;
    logic [31:0] held;
    // expected result
    two = 0; e_pa = 0; e_c = 0; e_b = 0;
    if (d1[1:0] == 2'b10 && !d1[18]) begin           // R5
      e_pa = {d1[31:20], va[19:0]}; e_c = d1[3]; e_b = d1[2]; e_f = 2'd0;
    end else if (d1[1:0] == 2'b10) e_f = 2'd2;        // R6
    else if (d1[1:0] == 2'b01) begin
      two = 1;
      if (d2[1:0] == 2'b10) begin                      // R9
        e_pa = {d2[31:12], va[11:0]}; e_c = d2[3]; e_b = d2[2]; e_f = 2'd0;
      end else e_f = 2'd3;                             // R10
    end else e_f = 2'd1;                               // R7

    @(negedge clk);
    check("R2 idle ready", {31'd0, req_ready}, 32'd1);
    req_valid = 1'b1; req_vaddr = va; tbl_base = base;
    @(negedge clk);
    req_valid = 1'b0;
    check("R2 busy after accept", {31'd0, req_ready}, 32'd0);
    if (poke) begin                                    // R2: offered requests are ignored
      req_valid = 1'b1; req_vaddr = ~va; tbl_base = ~base;
    end
    serve("R3 first fetch address", l1_addr(base, va), d1);
    if (two) serve("R8 second fetch address", l2_addr(d1, va), d2);
    while (!rsp_valid) @(negedge clk);
    check("R4 no fetch with response", {31'd0, mem_req}, 32'd0);
    check("R5 R9 paddr", rsp_paddr, e_pa);
    check("R5 R9 cacheable", {31'd0, rsp_cacheable}, {31'd0, e_c});
    check("R5 R9 bufferable", {31'd0, rsp_bufferable}, {31'd0, e_b});
    check("R6 R7 R10 fault", {30'd0, rsp_fault}, {30'd0, e_f});
    check("R11 domain", {28'd0, rsp_domain}, {28'd0, d1[8:5]});
    if (poke) check("R2 busy during walk", {31'd0, req_ready}, 32'd0);
    held = rsp_paddr;
    repeat ($urandom_range(0, 3)) @(negedge clk);
    check("R13 held valid", {31'd0, rsp_valid}, 32'd1);
    check("R13 held paddr", rsp_paddr, held);
    req_valid = 1'b0;
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
    check("R13 valid drops", {31'd0, rsp_valid}, 32'd0);
    check("R13 ready returns", {31'd0, req_ready}, 32'd1);
  endtask

  initial begin
    void'($urandom(32'd20240607));
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 req_ready", {31'd0, req_ready}, 32'd1);
    check("R1 mem_req", {31'd0, mem_req}, 32'd0);
    check("R1 rsp_valid", {31'd0, rsp_valid}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // Directed: section with C and B set (R5), L1 addr 0x0000448C (R3)
    walk(32'h1230ABCD, 18'h1, 32'h4560000E, 32'h0, 0);
    // Directed: coarse, second fetch at 0xABCDE114 (R8), small page C=1 B=0 (R9)
    walk(32'h12345678, 18'h1, 32'hABCDE001, 32'h9876500A, 1);
    // Directed: large section fault (R6), domain 0xF (R11)
    walk(32'hFFF00000, 18'h3FFFF, 32'h000401E2, 32'h0, 0);
    // Directed: L1 code 11 fault (R7), fault clears attributes (R12)
    walk(32'h00000000, 18'h0, 32'hFFFFFFFF, 32'h0, 1);
    // Directed: L1 code 00 fault (R7)
    walk(32'h80000123, 18'h2AAAA, 32'h0000000C, 32'h0, 0);
    // Directed: second level code 01 and 00 faults (R10)
    walk(32'h000FF000, 18'h1, 32'h00000121, 32'hFFFFFFFD, 0);
    walk(32'h7FFFFFFF, 18'h1, 32'h00000001, 32'hFFFFFFFC, 1);

    // Random walks over every descriptor class
    for (int i = 0; i < 400; i++) begin
      logic [31:0] d1, d2;
      int k;
      d1 = $urandom; d2 = $urandom;
      k = $urandom_range(0, 6);
      case (k)
        0, 1: begin d1[1:0] = 2'b10; d1[18] = 1'b0; end
        2:    begin d1[1:0] = 2'b10; d1[18] = 1'b1; end
        3:    d1[1:0] = 2'b00;
        4:    d1[1:0] = 2'b11;
        default: begin
          d1[1:0] = 2'b01;
          if ($urandom_range(0, 1) == 0) d2[1:0] = 2'b10;
        end
      endcase
      walk($urandom, 18'($urandom), d1, d2, $urandom_range(0, 3) == 0);
    end
    finish_run();
  end
endmodule